// File: doc/BRIEF.md
# Shift Unit with Multiply-Quotient Side Register

This block is a 32-bit shift and rotate execution unit coupled to a 32-bit side register, called MQ here, that older integer pipelines used to extend shifts past one word and to hold the high half of a product. Each accepted operation takes a source word A, an insert word B, a mask word M and a 6-bit shift amount. It produces a result word and, for most operations, a new MQ value. Shifts deposit a rotated copy of the source into MQ. The "with-MQ" forms merge bits from the MQ value held before the operation into the result, through a mask that depends on the shift amount.

The unit is a single registered stage. An operation presented with `valid_i` high is captured on a rising clock edge. The result, the new MQ and `res_valid_o` appear on the outputs after that edge. Back-to-back operations are allowed. Every operation reads the MQ value that was registered before its own edge, so a chain of extended shifts passes a word's spilled bits from one operation to the next through MQ.

Throughout, n is `amt_i[4:0]` and L is `amt_i[5]`. rotl/rotr are 32-bit rotations, `>>>` is the arithmetic right shift, and "old MQ" is the value of `mq_o` before the operation's capturing edge.

Top module: `xshift_mq_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `res_o`, `mq_o` and `res_valid_o` are all zero.
- R2: An operation with `valid_i` high at a rising edge shows its result and MQ after that edge, and `res_valid_o` is high for exactly that cycle. With `valid_i` low, `res_o` and `mq_o` keep their values and `res_valid_o` is low, whatever the other inputs carry.
- R3: Opcode 0 (shift-left-extended) sets MQ = rotl(A,n) and result = A << n. Opcode 5 (shift-left-extended-with-MQ) sets MQ = rotl(A,n) and result = (A << n) OR (old MQ >> (32-n)); the second term is zero when n = 0.
- R4: Opcode 1 (shift-right-extended) sets MQ = rotr(A,n) and result = A >>> n. Opcode 2 (algebraic extended) sets MQ = A >> n (logical) and result = A >>> n.
- R5: The left mask is LM = 0xFFFFFFFF << n, inverted when L = 1. Opcode 3 (long-left-with-MQ) gives result = ((A << n) AND LM) OR (old MQ AND NOT LM) and leaves MQ unchanged. Opcode 4 (left-with-MQ) gives result = rotl(A,n) AND LM and sets MQ = rotl(A,n).
- R6: The right mask is RM = 0x80000000 >>> n. Opcode 6 (right-extended-with-MQ) gives result = (A >> n) OR (old MQ AND RM). Opcode 7 (long-right-with-MQ) uses RL = RM, inverted when L = 1, and gives result = ((A >> n) AND RL) OR (old MQ AND NOT RL). Both set MQ = rotr(A,n).
- R7: Opcode 8 (right-with-MQ) gives result = A >> n. Opcode 9 (algebraic-with-MQ) gives result = A >>> n when L = 0, and 32 copies of A[31] when L = 1. Both set MQ = rotr(A,n).
- R8: Opcode 10 (rotate-with-mask-insert) gives result = (rotl(A,n) AND M) OR (B AND NOT M) and leaves MQ unchanged.
- R9: Opcode 11 (rotate-and-insert-bit) returns B with bit position (n+31) mod 32 replaced by A[31], and leaves MQ unchanged.
- R10: Opcode 12 (mask-insert) gives result = (A AND NOT M) OR (B AND M) and leaves MQ unchanged.
- R11: Opcode 13 (multiply) forms the unsigned 64-bit product A*B, puts bits 63:32 in MQ and returns bits 31:0.
- R12: Every MQ-merging operation uses the MQ written by the immediately preceding accepted operation, even when the two are back-to-back. MQ is never changed by opcodes 3, 10, 11 and 12.
- R13: Opcodes 14 and 15 are reserved: they return zero and leave MQ unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode (encodings in R3 to R13) |
| src_a_i | input | 32 | Source word A |
| src_b_i | input | 32 | Insert word / multiplier B |
| mask_i | input | 32 | Mask word M |
| amt_i | input | 6 | Shift amount; bits 4:0 are n, bit 5 is L |
| res_o | output | 32 | Registered result |
| mq_o | output | 32 | MQ register |
| res_valid_o | output | 1 | High the cycle after an accepted operation |

## Verification
The bench targets the edge cases of the shift amount:
- n = 0, where the merge term of opcode 5 must vanish rather than pass all of old MQ, and the right masks collapse to the sign bit.
- n = 31.
- L set with n = 0 and with n nonzero, where a design that forgets the mask inversion merges the wrong half of old MQ.
- Negative sources, where an arithmetic shift and a logical shift disagree.

It also runs chained operations that write MQ and then merge it on the next cycle; a design that reads MQ after the update would merge its own rotated source. The multiply is driven with all-ones operands, which exposes a product truncated to 32 bits or computed as signed. The rotate-and-insert-bit case at n = 0 lands on bit 31, which catches an off-by-one bit position.

// File: rtl/xsmq_pkg.sv
package xsmq_pkg;

    typedef enum logic [3:0] {
        OP_SHL_EXT     = 4'd0,
        OP_SHR_EXT     = 4'd1,
        OP_SHR_ALG_EXT = 4'd2,
        OP_SHL_LONG_MQ = 4'd3,
        OP_SHL_MQ      = 4'd4,
        OP_SHL_EXT_MQ  = 4'd5,
        OP_SHR_EXT_MQ  = 4'd6,
        OP_SHR_LONG_MQ = 4'd7,
        OP_SHR_MQ      = 4'd8,
        OP_SHR_ALG_MQ  = 4'd9,
        OP_ROT_INSERT  = 4'd10,
        OP_BIT_INSERT  = 4'd11,
        OP_MASK_INSERT = 4'd12,
        OP_MUL_WIDE    = 4'd13,
        OP_RSVD_14     = 4'd14,
        OP_RSVD_15     = 4'd15
    } xsmq_op_e;

endpackage

// File: rtl/xsmq_rotator.sv
module xsmq_rotator #(
    parameter int WIDTH = 32,
    localparam int LOG  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [LOG-1:0]   amt_i,
    output logic [WIDTH-1:0] rotl_o
);

    logic [WIDTH-1:0] stage [LOG+1];

    assign stage[0] = data_i;

    for (genvar k = 0; k < LOG; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k]
            ? {stage[k][WIDTH-1-STEP:0], stage[k][WIDTH-1:WIDTH-STEP]}
            : stage[k];
    end

    assign rotl_o = stage[LOG];

endmodule

// File: rtl/xsmq_maskgen.sv
module xsmq_maskgen #(
    parameter int WIDTH = 32,
    localparam int LOG  = $clog2(WIDTH)
) (
    input  logic [LOG:0]     amt_i,
    output logic [WIDTH-1:0] lmask_o,
    output logic [WIDTH-1:0] rmask_o,
    output logic [WIDTH-1:0] rmask_long_o,
    output logic [WIDTH-1:0] bitpos_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] TOP_BIT  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] LOW_BIT  = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [LOG-1:0]   n;
    logic             long_sel;
    logic [WIDTH-1:0] lmask_raw;
    logic [WIDTH-1:0] rmask_raw;

    assign n        = amt_i[LOG-1:0];
    assign long_sel = amt_i[LOG];

    always_comb begin
        lmask_raw    = ALL_ONES << n;
        rmask_raw    = $unsigned($signed(TOP_BIT) >>> n);
        lmask_o      = long_sel ? ~lmask_raw : lmask_raw;
        rmask_o      = rmask_raw;
        rmask_long_o = long_sel ? ~rmask_raw : rmask_raw;
        // rotating the top bit left by n lands on (n-1) mod WIDTH
        bitpos_o     = LOW_BIT << (n - LOG'(1));
    end

endmodule

// File: rtl/xsmq_alu.sv
module xsmq_alu
    import xsmq_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int LOG  = $clog2(WIDTH)
) (
    input  xsmq_op_e         op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] m_i,
    input  logic [LOG:0]     amt_i,
    input  logic [WIDTH-1:0] mq_old_i,
    input  logic [WIDTH-1:0] rot_l_i,
    input  logic [WIDTH-1:0] rot_r_i,
    input  logic [WIDTH-1:0] lmask_i,
    input  logic [WIDTH-1:0] rmask_i,
    input  logic [WIDTH-1:0] rmask_long_i,
    input  logic [WIDTH-1:0] bitpos_i,
    output logic [WIDTH-1:0] res_o,
    output logic [WIDTH-1:0] mq_o,
    output logic             mq_we_o
);

    logic [LOG-1:0]     n;
    logic               long_sel;
    logic [WIDTH-1:0]   shl;
    logic [WIDTH-1:0]   shr;
    logic [WIDTH-1:0]   sra;
    logic [WIDTH-1:0]   spill;
    logic [2*WIDTH-1:0] prod;

    assign n        = amt_i[LOG-1:0];
    assign long_sel = amt_i[LOG];

    always_comb begin
        shl   = a_i << n;
        shr   = a_i >> n;
        sra   = $unsigned($signed(a_i) >>> n);
        spill = (n == '0) ? '0 : (mq_old_i >> (WIDTH - int'(n)));
        prod  = (2*WIDTH)'(a_i) * (2*WIDTH)'(b_i);

        res_o   = '0;
        mq_o    = mq_old_i;
        mq_we_o = 1'b0;

        unique case (op_i)
            OP_SHL_EXT: begin
                res_o = shl;     mq_o = rot_l_i; mq_we_o = 1'b1;
            end
            OP_SHR_EXT: begin
                res_o = sra;     mq_o = rot_r_i; mq_we_o = 1'b1;
            end
            OP_SHR_ALG_EXT: begin
                res_o = sra;     mq_o = shr;     mq_we_o = 1'b1;
            end
            OP_SHL_LONG_MQ: begin
                res_o = (shl & lmask_i) | (mq_old_i & ~lmask_i);
            end
            OP_SHL_MQ: begin
                res_o = rot_l_i & lmask_i;
                mq_o  = rot_l_i; mq_we_o = 1'b1;
            end
            OP_SHL_EXT_MQ: begin
                res_o = shl | spill;
                mq_o  = rot_l_i; mq_we_o = 1'b1;
            end
            OP_SHR_EXT_MQ: begin
                res_o = shr | (mq_old_i & rmask_i);
                mq_o  = rot_r_i; mq_we_o = 1'b1;
            end
            OP_SHR_LONG_MQ: begin
                res_o = (shr & rmask_long_i) | (mq_old_i & ~rmask_long_i);
                mq_o  = rot_r_i; mq_we_o = 1'b1;
            end
            OP_SHR_MQ: begin
                res_o = shr;     mq_o = rot_r_i; mq_we_o = 1'b1;
            end
            OP_SHR_ALG_MQ: begin
                res_o = long_sel ? {WIDTH{a_i[WIDTH-1]}} : sra;
                mq_o  = rot_r_i; mq_we_o = 1'b1;
            end
            OP_ROT_INSERT: begin
                res_o = (rot_l_i & m_i) | (b_i & ~m_i);
            end
            OP_BIT_INSERT: begin
                res_o = (b_i & ~bitpos_i) | (a_i[WIDTH-1] ? bitpos_i : '0);
            end
            OP_MASK_INSERT: begin
                res_o = (a_i & ~m_i) | (b_i & m_i);
            end
            OP_MUL_WIDE: begin
                res_o   = prod[WIDTH-1:0];
                mq_o    = prod[2*WIDTH-1:WIDTH];
                mq_we_o = 1'b1;
            end
            default: begin
                res_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/xshift_mq_unit.sv
module xshift_mq_unit
    import xsmq_pkg::*;
#(
    parameter int WIDTH  = 32,
    localparam int LOG   = $clog2(WIDTH),
    localparam int AMT_W = LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [WIDTH-1:0] res_o,
    output logic [WIDTH-1:0] mq_o,
    output logic             res_valid_o
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic [WIDTH-1:0] mq;
        logic             vld;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [LOG-1:0]   n_fwd;
    logic [LOG-1:0]   n_back;
    logic [WIDTH-1:0] rot_l;
    logic [WIDTH-1:0] rot_r;
    logic [WIDTH-1:0] lmask;
    logic [WIDTH-1:0] rmask;
    logic [WIDTH-1:0] rmask_long;
    logic [WIDTH-1:0] bitpos;
    logic [WIDTH-1:0] alu_res;
    logic [WIDTH-1:0] alu_mq;
    logic             alu_mq_we;

    assign n_fwd  = amt_i[LOG-1:0];
    assign n_back = LOG'(0) - n_fwd;

    xsmq_rotator #(.WIDTH(WIDTH)) u_rot_left (
        .data_i (src_a_i),
        .amt_i  (n_fwd),
        .rotl_o (rot_l)
    );

    xsmq_rotator #(.WIDTH(WIDTH)) u_rot_right (
        .data_i (src_a_i),
        .amt_i  (n_back),
        .rotl_o (rot_r)
    );

    xsmq_maskgen #(.WIDTH(WIDTH)) u_masks (
        .amt_i        (amt_i),
        .lmask_o      (lmask),
        .rmask_o      (rmask),
        .rmask_long_o (rmask_long),
        .bitpos_o     (bitpos)
    );

    xsmq_alu #(.WIDTH(WIDTH)) u_alu (
        .op_i         (xsmq_op_e'(op_i)),
        .a_i          (src_a_i),
        .b_i          (src_b_i),
        .m_i          (mask_i),
        .amt_i        (amt_i),
        .mq_old_i     (st_q.mq),
        .rot_l_i      (rot_l),
        .rot_r_i      (rot_r),
        .lmask_i      (lmask),
        .rmask_i      (rmask),
        .rmask_long_i (rmask_long),
        .bitpos_i     (bitpos),
        .res_o        (alu_res),
        .mq_o         (alu_mq),
        .mq_we_o      (alu_mq_we)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.res = alu_res;
            if (alu_mq_we) begin
                st_d.mq = alu_mq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o       = st_q.res;
    assign mq_o        = st_q.mq;
    assign res_valid_o = st_q.vld;

endmodule

// File: rtl/xsmq_checker.sv
module xsmq_checker #(
    parameter int WIDTH  = 32,
    localparam int AMT_W = $clog2(WIDTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] src_a_i,
    input logic [WIDTH-1:0] src_b_i,
    input logic [WIDTH-1:0] mask_i,
    input logic [AMT_W-1:0] amt_i,
    input logic [WIDTH-1:0] res_o,
    input logic [WIDTH-1:0] mq_o,
    input logic             res_valid_o
);

    a_r1_reset_clears: assert property (@(posedge clk)
        $rose(rst_n) |-> (mq_o == '0 && res_o == '0 && !res_valid_o));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!res_valid_o && $stable(mq_o) && $stable(res_o)));

    a_r10_mask_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd12) |=>
        res_o == (($past(src_a_i) & ~$past(mask_i)) | ($past(src_b_i) & $past(mask_i))));

    a_r11_wide_product: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd13) |=>
        {mq_o, res_o} == ((2*WIDTH)'($past(src_a_i)) * (2*WIDTH)'($past(src_b_i))));

    a_r12_mq_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 4'd3 || op_i == 4'd10 || op_i == 4'd11 || op_i == 4'd12))
        |=> $stable(mq_o));

    a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i >= 4'd14) |=> (res_o == '0 && $stable(mq_o)));

    a_r9_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd11) |=> $countones(res_o ^ $past(src_b_i)) <= 1);

endmodule

bind xshift_mq_unit xsmq_checker #(.WIDTH(WIDTH)) u_xsmq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .mask_i      (mask_i),
    .amt_i       (amt_i),
    .res_o       (res_o),
    .mq_o        (mq_o),
    .res_valid_o (res_valid_o)
);

// File: tb/xshift_mq_unit_bench.sv
`timescale 1ns/1ps
module xshift_mq_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] mask_i = '0;
    logic [5:0]  amt_i = '0;
    logic [31:0] res_o;
    logic [31:0] mq_o;
    logic        res_valid_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] model_mq = '0;
    logic [31:0] last_res = '0;

    always #4 clk = ~clk;

    xshift_mq_unit u_xshift_mq_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .mask_i(mask_i), .amt_i(amt_i),
        .res_o(res_o), .mq_o(mq_o), .res_valid_o(res_valid_o)
    );

    function automatic logic [31:0] f_rotl(logic [31:0] x, int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[(i + n) % 32] = x[i];
        return r;
    endfunction

    function automatic logic [31:0] f_sra(logic [31:0] x, int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i + n] : x[31];
        return r;
    endfunction

    function automatic logic [31:0] f_srl(logic [31:0] x, int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i + n] : 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] f_sll(logic [31:0] x, int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i >= n) ? x[i - n] : 1'b0;
        return r;
    endfunction

    // returns {new_mq, result}
    function automatic logic [63:0] f_model(int op, logic [31:0] a, logic [31:0] b,
                                            logic [31:0] m, logic [5:0] amt,
                                            logic [31:0] mq);
        int n = int'(amt[4:0]);
        bit lng = amt[5];
        logic [31:0] rl = f_rotl(a, n);
        logic [31:0] rr = f_rotl(a, (32 - n) % 32);
        logic [31:0] lm = f_sll(32'hFFFF_FFFF, n);
        logic [31:0] rm = f_sra(32'h8000_0000, n);
        logic [31:0] rml;
        logic [31:0] r = '0;
        logic [31:0] q = mq;
        logic [63:0] p;
        if (lng) lm = ~lm;
        rml = lng ? ~rm : rm;
        case (op)
            0:  begin r = f_sll(a, n); q = rl; end
            1:  begin r = f_sra(a, n); q = rr; end
            2:  begin r = f_sra(a, n); q = f_srl(a, n); end
            3:  r = (f_sll(a, n) & lm) | (mq & ~lm);
            4:  begin r = rl & lm; q = rl; end
            5:  begin r = f_sll(a, n) | ((n == 0) ? 32'h0 : f_srl(mq, 32 - n)); q = rl; end
            6:  begin r = f_srl(a, n) | (mq & rm); q = rr; end
            7:  begin r = (f_srl(a, n) & rml) | (mq & ~rml); q = rr; end
            8:  begin r = f_srl(a, n); q = rr; end
            9:  begin r = lng ? {32{a[31]}} : f_sra(a, n); q = rr; end
            10: r = (rl & m) | (b & ~m);
            11: begin r = b; r[(n + 31) % 32] = a[31]; end
            12: r = (a & ~m) | (b & m);
            13: begin p = 64'(a) * 64'(b); r = p[31:0]; q = p[63:32]; end
            default: r = '0;
        endcase
        return {q, r};
    endfunction

    function automatic string f_tag(int op);
        case (op)
            0, 5:       return "R3";
            1, 2:       return "R4";
            3, 4:       return "R5";
            6, 7:       return "R6";
            8, 9:       return "R7";
            10:         return "R8";
            11:         return "R9";
            12:         return "R10";
            13:         return "R11";
            default:    return "R13";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic do_op(string tag, int op, logic [31:0] a, logic [31:0] b,
                         logic [31:0] m, logic [5:0] amt);
        logic [63:0] e;
        e = f_model(op, a, b, m, amt, model_mq);
        valid_i = 1'b1; op_i = 4'(op); src_a_i = a; src_b_i = b; mask_i = m; amt_i = amt;
        @(negedge clk);
        valid_i = 1'b0;
        check(tag, "result", res_o, e[31:0]);
        check(tag, "mq", mq_o, e[63:32]);
        check("R2", "res_valid", 32'(res_valid_o), 32'd1);
        model_mq = e[63:32];
        last_res = e[31:0];
    endtask

    task automatic idle_cycle();
        valid_i = 1'b0; op_i = 4'($urandom % 16); src_a_i = $urandom; src_b_i = $urandom;
        mask_i = $urandom; amt_i = 6'($urandom);
        @(negedge clk);
        check("R2", "idle result", res_o, last_res);
        check("R2", "idle mq", mq_o, model_mq);
        check("R2", "idle res_valid", 32'(res_valid_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "reset result", res_o, 32'h0);
        check("R1", "reset mq", mq_o, 32'h0);
        check("R1", "reset res_valid", 32'(res_valid_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset mq", mq_o, 32'h0);

        // directed corner cases
        do_op("R3", 0, 32'h8000_0001, 0, 0, 6'd0);
        do_op("R3", 0, 32'hF00D_BEEF, 0, 0, 6'd31);
        do_op("R3", 5, 32'h1234_5678, 0, 0, 6'd0);
        do_op("R12", 5, 32'h0000_00FF, 0, 0, 6'd8);
        do_op("R4", 1, 32'h8000_0010, 0, 0, 6'd4);
        do_op("R4", 2, 32'hFFFF_0000, 0, 0, 6'd31);
        do_op("R5", 3, 32'hAAAA_5555, 0, 0, 6'd40);
        do_op("R5", 3, 32'hAAAA_5555, 0, 0, 6'd32);
        do_op("R5", 4, 32'h1357_9BDF, 0, 0, 6'd36);
        do_op("R6", 6, 32'h7FFF_FFFF, 0, 0, 6'd0);
        do_op("R6", 7, 32'hC0DE_F00D, 0, 0, 6'd44);
        do_op("R6", 7, 32'hC0DE_F00D, 0, 0, 6'd32);
        do_op("R7", 8, 32'h8000_0000, 0, 0, 6'd31);
        do_op("R7", 9, 32'h8000_0000, 0, 0, 6'd32);
        do_op("R7", 9, 32'h4000_0000, 0, 0, 6'd35);
        do_op("R8", 10, 32'h8765_4321, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 6'd12);
        do_op("R9", 11, 32'h8000_0000, 32'h0000_0000, 0, 6'd0);
        do_op("R9", 11, 32'h0000_0000, 32'hFFFF_FFFF, 0, 6'd1);
        do_op("R10", 12, 32'hFFFF_0000, 32'h00FF_00FF, 32'hF0F0_F0F0, 6'd0);
        do_op("R11", 13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 6'd0);
        do_op("R12", 3, 32'h0000_0001, 0, 0, 6'd1);
        do_op("R13", 14, 32'hDEAD_BEEF, 32'h1, 32'h2, 6'd3);
        do_op("R13", 15, 32'hDEAD_BEEF, 32'h1, 32'h2, 6'd3);
        idle_cycle();
        idle_cycle();

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op = int'($urandom % 16);
            logic [5:0] amt;
            case ($urandom % 5)
                0: amt = 6'd0;
                1: amt = 6'd31;
                2: amt = 6'd32;
                default: amt = 6'($urandom);
            endcase
            do_op(f_tag(op), op, $urandom, $urandom, $urandom, amt);
            if ($urandom % 8 == 0) idle_cycle();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule